// File: doc/BRIEF.md
# Two-Sided Indirect Register Port

This block sits between a CPU bus and two independent controller register files, one for a host-side controller and one for a device-side controller. The CPU sees four locations, chosen by a two-bit address. For each side there is a command location and a data location. To reach a register, software first writes the register's index to the command location of a side. It then reads or writes that register through the same side's data location. Each side keeps its own index, so software may interleave host-side and device-side accesses freely.

Each side has a small register set: a read-only identity word, a scratch word, an event status word, an event enable word and an interrupt mode word. Event inputs set status bits. Software clears them by writing ones. The enabled, pending status of a side drives that side's interrupt pin. The pin's shape is chosen per side: a level in either polarity, or a fixed-width pulse in either polarity.

The bus is a plain asynchronous-style strobe interface that is sampled on the clock. It has no stream data path, so there is no valid/ready handshake and no back-pressure. Each assertion of a strobe is one access. Read data is registered and held until the next read.

Top module: `dual_regport`

## Requirements
- R1: Address 2'b00 selects the host data location, 2'b01 the host command location, 2'b10 the device data location and 2'b11 the device command location.
- R2: A write to a command location stores wdata[2:0] as that side's index, and a read of a command location returns the index zero-extended. Each low-going edge of (cs_n OR wr_n) or (cs_n OR rd_n) is exactly one access, however long the strobe stays low. Strobes have no effect while cs_n is high, and rdata changes only on a read access.
- R3: Each side keeps its own index. A command write to one side never changes the other side's index or the register it reaches.
- R4: Until a side's index has been written after reset, a read of its data location returns 0 and a write to it is ignored.
- R5: Index map, per side: 0 is a read-only identity word (host 16'hA0C1, device 16'hD0E5); 1 is a 16-bit read/write scratch word; 2 is the 8-bit event status; 3 is the 8-bit event enable; 4 is the interrupt mode in bits 1:0. Indices 5 to 7 read 0 and ignore writes. Narrow registers read with zeros above their width.
- R6: An event input bit that is high at a clock edge sets the matching status bit. When a set and a clear of the same bit fall on the same edge, the set wins.
- R7: Writing 1s to the status register clears those bits. Bits written with 0 are kept.
- R8: Mode 0 (active-high level): the interrupt pin equals OR(status AND enable) from one clock earlier.
- R9: Mode 1 (active-low level): the interrupt pin is the inverse of the mode 0 output.
- R10: Mode 2 (high pulse): when OR(status AND enable) goes from 0 to nonzero, the pin goes high one clock later for exactly 4 clocks. Otherwise it is low.
- R11: Mode 3 (low pulse): the pin idles high and drops low for exactly 4 clocks, with the same trigger and timing as R10.
- R12: An active-low reset clears both indices to "not written", all read/write registers and status to 0, the mode to 0, rdata to 0 and both interrupt pins to low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Location select: bit 1 = side (0 host, 1 device), bit 0 = command (1) or data (0) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| host_evt | input | 8 | Host-side event inputs, setting host status bits |
| dev_evt | input | 8 | Device-side event inputs, setting device status bits |
| host_irq | output | 1 | Host-side interrupt pin |
| dev_irq | output | 1 | Device-side interrupt pin |

## Verification
An access takes effect at the first rising edge that sees its strobe low. Any written register, and rdata for a read, is valid right after that edge. Interrupt pins follow a status, enable or event change one edge later, and a pulse holds for the 4 edges after that; a mode change alters the pin at once. The bench drives inputs and samples outputs on falling edges. It holds each strobe across two rising edges, reads back after the strobe period, and counts pulse width one falling edge at a time starting at the predicted edge.

// File: rtl/regport_pkg.sv
package regport_pkg;

  localparam int NUM_SIDES = 2;

  typedef enum logic [1:0] {
    IRQ_LVL_HI   = 2'd0,
    IRQ_LVL_LO   = 2'd1,
    IRQ_PULSE_HI = 2'd2,
    IRQ_PULSE_LO = 2'd3
  } irq_mode_e;

  typedef enum logic [2:0] {
    RI_IDENT   = 3'd0,
    RI_SCRATCH = 3'd1,
    RI_STATUS  = 3'd2,
    RI_ENABLE  = 3'd3,
    RI_MODE    = 3'd4
  } reg_idx_e;

  typedef struct packed {
    logic idx_we;
    logic dat_we;
  } side_req_t;

endpackage

// File: rtl/regport_bus_front.sv
module regport_bus_front
  import regport_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n,
  input  logic      rd_n,
  input  logic      wr_n,
  input  logic [1:0] addr,
  output side_req_t req [NUM_SIDES],
  output logic      rd_fire
);

  logic wr_act, rd_act, wr_q, rd_q, wr_fire;

  assign wr_act = ~cs_n & ~wr_n;
  assign rd_act = ~cs_n & ~rd_n;

  // one access per strobe assertion: act only on the first sampled cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end

  assign wr_fire = wr_act & ~wr_q;
  assign rd_fire = rd_act & ~rd_q & ~wr_act;

  // bit 1 picks the side, bit 0 picks command (1) or data (0)
  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_sel
    assign req[s].idx_we = wr_fire & (addr[1] == 1'(s)) &  addr[0];
    assign req[s].dat_we = wr_fire & (addr[1] == 1'(s)) & ~addr[0];
  end

endmodule

// File: rtl/regport_irq_shaper.sv
module regport_irq_shaper
  import regport_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      masked,
  input  irq_mode_e mode,
  output logic      irq
);

  localparam int CW = $clog2(PULSE_LEN + 1);

  logic          lvl_q;
  logic [CW-1:0] cnt;
  logic          pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt   <= '0;
    end else begin
      lvl_q <= masked;
      if (masked && !lvl_q)  cnt <= CW'(PULSE_LEN);
      else if (cnt != '0)    cnt <= cnt - CW'(1);
    end
  end

  assign pulse = (cnt != '0);

  always_comb begin
    unique case (mode)
      IRQ_LVL_HI:   irq = lvl_q;
      IRQ_LVL_LO:   irq = ~lvl_q;
      IRQ_PULSE_HI: irq = pulse;
      IRQ_PULSE_LO: irq = ~pulse;
      default:      irq = lvl_q;
    endcase
  end

endmodule

// File: rtl/regport_side.sv
module regport_side
  import regport_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          EVT_W     = 8,
  parameter int          IDX_W     = 3,
  parameter logic [15:0] IDENT     = 16'h0000,
  parameter int          PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  side_req_t         req,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EVT_W-1:0]  evt,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] rd_val,
  output irq_mode_e         mode_o,
  output logic              masked_o,
  output logic              irq
);

  localparam logic [IDX_W-1:0] I_IDENT   = IDX_W'(RI_IDENT);
  localparam logic [IDX_W-1:0] I_SCRATCH = IDX_W'(RI_SCRATCH);
  localparam logic [IDX_W-1:0] I_STATUS  = IDX_W'(RI_STATUS);
  localparam logic [IDX_W-1:0] I_ENABLE  = IDX_W'(RI_ENABLE);
  localparam logic [IDX_W-1:0] I_MODE    = IDX_W'(RI_MODE);

  logic [IDX_W-1:0]  idx;
  logic              idx_vld;
  logic [DATA_W-1:0] scratch;
  logic [EVT_W-1:0]  status, enable, clr_mask;
  irq_mode_e         mode;
  logic              hit;

  assign hit      = req.dat_we & idx_vld;
  assign clr_mask = (hit && idx == I_STATUS) ? wdata[EVT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      idx_vld <= 1'b0;
      scratch <= '0;
      status  <= '0;
      enable  <= '0;
      mode    <= IRQ_LVL_HI;
    end else begin
      if (req.idx_we) begin
        idx     <= wdata[IDX_W-1:0];
        idx_vld <= 1'b1;
      end
      if (hit && idx == I_SCRATCH) scratch <= wdata;
      if (hit && idx == I_ENABLE)  enable  <= wdata[EVT_W-1:0];
      if (hit && idx == I_MODE)    mode    <= irq_mode_e'(wdata[1:0]);
      // set takes priority over a same-edge clear
      status <= (status & ~clr_mask) | evt;
    end
  end

  always_comb begin
    rd_val = '0;
    if (idx_vld) begin
      case (idx)
        I_IDENT:   rd_val = DATA_W'(IDENT);
        I_SCRATCH: rd_val = scratch;
        I_STATUS:  rd_val[EVT_W-1:0] = status;
        I_ENABLE:  rd_val[EVT_W-1:0] = enable;
        I_MODE:    rd_val[1:0] = mode;
        default:   rd_val = '0;
      endcase
    end
  end

  assign idx_o    = idx;
  assign mode_o   = mode;
  assign masked_o = |(status & enable);

  regport_irq_shaper #(.PULSE_LEN(PULSE_LEN)) u_shape (
    .clk    (clk),
    .rst_n  (rst_n),
    .masked (masked_o),
    .mode   (mode),
    .irq    (irq)
  );

endmodule

// File: rtl/dual_regport.sv
module dual_regport
  import regport_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          EVT_W     = 8,
  parameter int          IDX_W     = 3,
  parameter logic [15:0] HOST_ID   = 16'hA0C1,
  parameter logic [15:0] DEV_ID    = 16'hD0E5,
  parameter int          PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [EVT_W-1:0]  host_evt,
  input  logic [EVT_W-1:0]  dev_evt,
  output logic              host_irq,
  output logic              dev_irq
);

  side_req_t         req        [NUM_SIDES];
  logic [EVT_W-1:0]  evt        [NUM_SIDES];
  logic [IDX_W-1:0]  side_idx   [NUM_SIDES];
  logic [DATA_W-1:0] side_rd    [NUM_SIDES];
  irq_mode_e         side_mode  [NUM_SIDES];
  logic              side_masked[NUM_SIDES];
  logic              side_irq   [NUM_SIDES];
  logic              rd_fire;
  logic [DATA_W-1:0] idx_ext;

  regport_bus_front u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr    (addr),
    .req     (req),
    .rd_fire (rd_fire)
  );

  assign evt[0] = host_evt;
  assign evt[1] = dev_evt;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    regport_side #(
      .DATA_W    (DATA_W),
      .EVT_W     (EVT_W),
      .IDX_W     (IDX_W),
      .IDENT     ((s == 0) ? HOST_ID : DEV_ID),
      .PULSE_LEN (PULSE_LEN)
    ) u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req[s]),
      .wdata    (wdata),
      .evt      (evt[s]),
      .idx_o    (side_idx[s]),
      .rd_val   (side_rd[s]),
      .mode_o   (side_mode[s]),
      .masked_o (side_masked[s]),
      .irq      (side_irq[s])
    );
  end

  always_comb begin
    idx_ext = '0;
    idx_ext[IDX_W-1:0] = side_idx[addr[1]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (rd_fire) rdata <= addr[0] ? idx_ext : side_rd[addr[1]];
  end

  assign host_irq = side_irq[0];
  assign dev_irq  = side_irq[1];

endmodule

// File: rtl/regport_checker.sv
module regport_checker #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rdata,
  input logic              host_irq,
  input logic [1:0]        h_mode,
  input logic              h_masked,
  input logic [IDX_W-1:0]  h_idx,
  input logic [IDX_W-1:0]  d_idx
);

  logic rd_act, wr_act, rd_q, wr_q, rd_new, wr_new;

  assign rd_act = ~cs_n & ~rd_n;
  assign wr_act = ~cs_n & ~wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end

  assign rd_new = rd_act & ~rd_q & ~wr_act;
  assign wr_new = wr_act & ~wr_q;

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_new |=> $stable(rdata));

  p_cs_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(h_idx) && $stable(d_idx)));

  p_host_idx_private_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_new && addr == 2'b01) |=> $stable(h_idx));

  p_level_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_mode == 2'd0 && $past(h_mode) == 2'd0) |-> (host_irq == $past(h_masked)));

  p_level_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_mode == 2'd1 && $past(h_mode) == 2'd1) |-> (host_irq == !$past(h_masked)));

  p_pulse_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_mode == 2'd2 && h_masked && !$past(h_masked)) |=> (h_mode != 2'd2 || host_irq));

endmodule

bind dual_regport regport_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .addr     (addr),
  .rdata    (rdata),
  .host_irq (host_irq),
  .h_mode   (side_mode[0]),
  .h_masked (side_masked[0]),
  .h_idx    (side_idx[0]),
  .d_idx    (side_idx[1])
);

// File: tb/tb_dual_regport.sv
module tb_dual_regport;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  host_evt = '0, dev_evt = '0;
  logic        host_irq, dev_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  dual_regport dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .host_evt(host_evt), .dev_evt(dev_evt),
    .host_irq(host_irq), .dev_irq(dev_irq)
  );

  typedef struct packed {
    logic        rd;
    logic [1:0]  a;
    logic [15:0] d;
    logic [15:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 29;
  // rd, addr, wdata, expected, requirement number
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'b00, 16'h0000, 16'h0000, 4'd4},  // R4 host data before index
    '{1'b0, 2'b00, 16'h1234, 16'h0000, 4'd4},  // R4 write ignored
    '{1'b0, 2'b01, 16'h0001, 16'h0000, 4'd2},
    '{1'b1, 2'b01, 16'h0000, 16'h0001, 4'd2},  // R2 index readback, R1 host cmd
    '{1'b1, 2'b00, 16'h0000, 16'h0000, 4'd4},  // R4 earlier write had no effect
    '{1'b0, 2'b00, 16'hBEEF, 16'h0000, 4'd5},
    '{1'b1, 2'b00, 16'h0000, 16'hBEEF, 4'd5},  // R5 scratch, R1 host data
    '{1'b1, 2'b10, 16'h0000, 16'h0000, 4'd4},  // R4 device data before index
    '{1'b0, 2'b11, 16'h0000, 16'h0000, 4'd1},
    '{1'b1, 2'b10, 16'h0000, 16'hD0E5, 4'd1},  // R1 device ports
    '{1'b0, 2'b10, 16'hFFFF, 16'h0000, 4'd5},
    '{1'b1, 2'b10, 16'h0000, 16'hD0E5, 4'd5},  // R5 identity read-only
    '{1'b1, 2'b00, 16'h0000, 16'hBEEF, 4'd3},  // R3 host untouched
    '{1'b0, 2'b11, 16'h0001, 16'h0000, 4'd3},
    '{1'b0, 2'b10, 16'h5A5A, 16'h0000, 4'd3},
    '{1'b1, 2'b10, 16'h0000, 16'h5A5A, 4'd3},
    '{1'b1, 2'b00, 16'h0000, 16'hBEEF, 4'd3},  // R3 same index, separate files
    '{1'b0, 2'b01, 16'h000B, 16'h0000, 4'd2},
    '{1'b1, 2'b01, 16'h0000, 16'h0003, 4'd2},  // R2 only low three bits kept
    '{1'b0, 2'b00, 16'hFFF0, 16'h0000, 4'd5},
    '{1'b1, 2'b00, 16'h0000, 16'h00F0, 4'd5},  // R5 enable is 8 bits
    '{1'b0, 2'b01, 16'h0006, 16'h0000, 4'd5},
    '{1'b0, 2'b00, 16'hFFFF, 16'h0000, 4'd5},
    '{1'b1, 2'b00, 16'h0000, 16'h0000, 4'd5},  // R5 unused index
    '{1'b0, 2'b01, 16'h0004, 16'h0000, 4'd5},
    '{1'b0, 2'b00, 16'hFFFE, 16'h0000, 4'd5},
    '{1'b1, 2'b00, 16'h0000, 16'h0002, 4'd5},  // R5 mode is 2 bits
    '{1'b0, 2'b00, 16'h0000, 16'h0000, 4'd5},
    '{1'b1, 2'b01, 16'h0000, 16'h0004, 4'd2}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic rd, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = a; wdata = d;
    if (rd) rd_n = 1'b0; else wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic host_event(input logic [7:0] v);
    @(negedge clk); host_evt = v;
    @(negedge clk); host_evt = '0;
  endtask

  task automatic count_level(input logic lvl, output int cnt, output logic first);
    cnt = 0;
    @(negedge clk);
    first = (host_irq == lvl);
    if (first) cnt++;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (host_irq == lvl) cnt++;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int   cnt;
    logic first;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 rdata", rdata, 16'h0);
    chk("R12 irq", {14'h0, host_irq, dev_irq}, 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i].rd, VEC[i].a, VEC[i].d);
      if (VEC[i].rd) chk($sformatf("R%0d vec%0d", VEC[i].r, i), rdata, VEC[i].e);
    end

    // R2 strobe without chip select is ignored
    @(negedge clk); wr_n = 1'b0; addr = 2'b01; wdata = 16'h0007;
    repeat (2) @(negedge clk); wr_n = 1'b1;
    bus(1'b1, 2'b01, 16'h0);
    chk("R2 cs gating", rdata, 16'h0004);

    // host: status index, mode 0, enable F0 (set in table)
    bus(1'b0, 2'b01, 16'h0002);
    host_event(8'h10);
    @(negedge clk);
    chk("R8 level high", {15'h0, host_irq}, 16'h1);
    host_event(8'h01);
    bus(1'b1, 2'b00, 16'h0);
    chk("R6 status set", rdata, 16'h0011);
    bus(1'b0, 2'b00, 16'h0010);
    bus(1'b1, 2'b00, 16'h0);
    chk("R7 w1c", rdata, 16'h0001);
    chk("R8 level drops", {15'h0, host_irq}, 16'h0);

    // R6 set beats clear on the same edge
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 2'b00; wdata = 16'h0002; host_evt = 8'h02;
    @(negedge clk);
    host_evt = '0; cs_n = 1'b1; wr_n = 1'b1;
    bus(1'b1, 2'b00, 16'h0);
    chk("R6 set wins", rdata, 16'h0003);
    bus(1'b0, 2'b00, 16'h00FF);
    bus(1'b1, 2'b00, 16'h0);
    chk("R7 clear all", rdata, 16'h0000);

    // R9 active-low level
    bus(1'b0, 2'b01, 16'h0004);
    bus(1'b0, 2'b00, 16'h0001);
    chk("R9 idle high", {15'h0, host_irq}, 16'h1);
    host_event(8'h20);
    @(negedge clk);
    chk("R9 asserted low", {15'h0, host_irq}, 16'h0);
    bus(1'b0, 2'b01, 16'h0002);
    bus(1'b0, 2'b00, 16'h00FF);
    bus(1'b0, 2'b01, 16'h0004);

    // R10 high pulse of 4 clocks
    bus(1'b0, 2'b00, 16'h0002);
    chk("R10 idle low", {15'h0, host_irq}, 16'h0);
    host_event(8'h40);
    count_level(1'b1, cnt, first);
    chk("R10 pulse start", {15'h0, first}, 16'h1);
    chk("R10 pulse width", 16'(cnt), 16'd4);
    bus(1'b0, 2'b01, 16'h0002);
    bus(1'b0, 2'b00, 16'h00FF);
    bus(1'b0, 2'b01, 16'h0004);

    // R11 low pulse of 4 clocks
    bus(1'b0, 2'b00, 16'h0003);
    chk("R11 idle high", {15'h0, host_irq}, 16'h1);
    host_event(8'h80);
    count_level(1'b0, cnt, first);
    chk("R11 pulse start", {15'h0, first}, 16'h1);
    chk("R11 pulse width", 16'(cnt), 16'd4);
    chk("R11 back high", {15'h0, host_irq}, 16'h1);

    // R12 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R12 irq after reset", {15'h0, host_irq}, 16'h0);
    chk("R12 rdata after reset", rdata, 16'h0);
    rst_n = 1'b1;
    bus(1'b1, 2'b00, 16'h0);
    chk("R12 index cleared", rdata, 16'h0);
    bus(1'b1, 2'b11, 16'h0);
    chk("R12 device index", rdata, 16'h0);

    finish_run();
  end

endmodule